// File: doc/BRIEF.md
# Host-Target Mailbox Interface

This block is a small memory-mapped mailbox through which software on a target core talks to a host-side service. It holds two 64-bit registers. The outbox carries a request from the target to the host. The inbox carries an acknowledge from the host back to the target. Each register appears on a 32-bit register bus as a low word and a high word. Every access is one full 32-bit word, so the bus has no byte enables.

A write to the outbox high word stores that word and then decodes the complete 64-bit outbox as one request. Bits 63:56 name a device and bits 55:48 name a command. The value 1 on its own is a shutdown request, which sets a sticky power-off output. A character request places the low byte of the outbox on a valid/ready stream port. When that byte is accepted, the outbox clears and the inbox takes an acknowledge word. A discard request only clears the outbox. Any other value stays in the registers and raises a sticky unsupported-request flag. While a character waits on the stream port, the block refuses register writes through `bus_ready`.

Top module: `hostmbx_top`

## Requirements
- R1: Byte offset 0 reads the outbox low word, 4 the outbox high word, 8 the inbox low word and 12 the inbox high word. `bus_rdata` follows `bus_addr` in the same cycle.
- R2: Any other offset reads as zero, including offsets that are not word aligned and offsets at or above 16. A write to such an offset changes no register.
- R3: A write to offset 0, 8 or 12 replaces only that 32-bit word and starts no request.
- R4: A write to offset 4 replaces the outbox high word. The resulting 64-bit outbox is then decoded as a request in the same clock edge.
- R5: When the decoded outbox equals 1, `halt` rises in the next cycle and stays high until reset. Both registers keep their values.
- R6: When bits 63:56 equal 1 and bits 55:48 equal 1, `chr_valid` rises in the next cycle with `chr_data` equal to outbox bits 7:0. Both stay steady until `chr_ready` is seen.
- R7: In the edge where `chr_valid` and `chr_ready` are both high, the outbox clears and the inbox becomes 0x0101_0000_0000_0000. `chr_valid` is low in the next cycle.
- R8: While a character is pending, `bus_ready` is low and bus writes are ignored.
- R9: When bits 63:56 equal 1 and bits 55:48 equal 0, the outbox clears in the next cycle. The inbox is left as it is and no character is produced.
- R10: Any other decoded value stays in the outbox. It sets `bad_cmd`, which stays high until reset.
- R11: Reset clears both registers, the pending character, `halt` and `bad_cmd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, combinational on bus_addr |
| bus_ready | output | 1 | Writes accepted when high |
| chr_valid | output | 1 | Output character present |
| chr_ready | input | 1 | Sink accepts the character |
| chr_data | output | 8 | Output character |
| halt | output | 1 | Sticky power-off request |
| bad_cmd | output | 1 | Sticky unsupported-request flag |

## Verification
The bench uses the default parameters: a 32-bit bus, 64-bit registers and a 5-bit offset. With a 5-bit offset the bench can reach unaligned offsets and offsets past the register window, as well as the four mapped words. A behavioural model tracks both registers and the flags and is compared on every clock. The character sink is stalled for several cycles, so the hold-back of the clear and acknowledge and the refused writes during a stall are both exercised. Shutdown, discard and unsupported values are each sent after other traffic, to show that their effects on the registers are kept apart.

// File: rtl/hostmbx_pkg.sv
package hostmbx_pkg;
    localparam int FIELD_W = 8;
    localparam logic [FIELD_W-1:0] CHAR_DEV = 8'd1;
    localparam logic [FIELD_W-1:0] PUT_CMD  = 8'd1;
    localparam logic [FIELD_W-1:0] DROP_CMD = 8'd0;

    typedef enum logic [1:0] {
        K_HALT = 2'd0,
        K_PUT  = 2'd1,
        K_DROP = 2'd2,
        K_BAD  = 2'd3
    } cmd_kind_e;
endpackage

// File: rtl/hostmbx_decode.sv
module hostmbx_decode #(
    parameter int REG_W = 64
) (
    input  logic [REG_W-1:0]       word,
    output hostmbx_pkg::cmd_kind_e kind
);
    import hostmbx_pkg::*;
    localparam int DEV_HI = REG_W - 1;
    localparam int CMD_HI = REG_W - 1 - FIELD_W;

    logic [FIELD_W-1:0] dev_f;
    logic [FIELD_W-1:0] cmd_f;

    assign dev_f = word[DEV_HI -: FIELD_W];
    assign cmd_f = word[CMD_HI -: FIELD_W];

    always_comb begin
        if (word == REG_W'(1))
            kind = K_HALT;
        else if (dev_f == CHAR_DEV && cmd_f == PUT_CMD)
            kind = K_PUT;
        else if (dev_f == CHAR_DEV && cmd_f == DROP_CMD)
            kind = K_DROP;
        else
            kind = K_BAD;
    end
endmodule

// File: rtl/hostmbx_rdmux.sv
module hostmbx_rdmux #(
    parameter int BUS_W  = 32,
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [2*BUS_W-1:0] outbox,
    input  logic [2*BUS_W-1:0] inbox,
    output logic [BUS_W-1:0]   rdata
);
    always_comb begin
        case (addr)
            ADDR_W'(0):  rdata = outbox[BUS_W-1:0];
            ADDR_W'(4):  rdata = outbox[2*BUS_W-1:BUS_W];
            ADDR_W'(8):  rdata = inbox[BUS_W-1:0];
            ADDR_W'(12): rdata = inbox[2*BUS_W-1:BUS_W];
            default:     rdata = '0;
        endcase
    end
endmodule

// File: rtl/hostmbx_top.sv
module hostmbx_top #(
    parameter int BUS_W  = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              bus_ready,
    output logic              chr_valid,
    input  logic              chr_ready,
    output logic [7:0]        chr_data,
    output logic              halt,
    output logic              bad_cmd
);
    import hostmbx_pkg::*;
    localparam int REG_W = 2 * BUS_W;
    localparam logic [REG_W-1:0] ACK_WORD = {CHAR_DEV, PUT_CMD, {(REG_W-2*FIELD_W){1'b0}}};

    typedef struct packed {
        logic [REG_W-1:0] outbox;
        logic [REG_W-1:0] inbox;
        logic             pend;
        logic             halt;
        logic             bad;
    } state_t;

    state_t           st_d, st_q;
    logic [REG_W-1:0] cand_d;
    cmd_kind_e        kind_d;
    logic             wr_ok_d;

    assign cand_d = {bus_wdata, st_q.outbox[BUS_W-1:0]};

    hostmbx_decode #(.REG_W(REG_W)) i_decode (
        .word (cand_d),
        .kind (kind_d)
    );

    hostmbx_rdmux #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) i_rdmux (
        .addr   (bus_addr),
        .outbox (st_q.outbox),
        .inbox  (st_q.inbox),
        .rdata  (bus_rdata)
    );

    always_comb begin
        st_d    = st_q;
        wr_ok_d = bus_valid && bus_write && !st_q.pend;
        if (st_q.pend && chr_ready) begin
            st_d.outbox = '0;
            st_d.inbox  = ACK_WORD;
            st_d.pend   = 1'b0;
        end else if (wr_ok_d) begin
            case (bus_addr)
                ADDR_W'(0):  st_d.outbox[BUS_W-1:0] = bus_wdata;
                ADDR_W'(8):  st_d.inbox[BUS_W-1:0] = bus_wdata;
                ADDR_W'(12): st_d.inbox[REG_W-1:BUS_W] = bus_wdata;
                ADDR_W'(4): begin
                    st_d.outbox = cand_d;
                    case (kind_d)
                        K_HALT:  st_d.halt   = 1'b1;
                        K_PUT:   st_d.pend   = 1'b1;
                        K_DROP:  st_d.outbox = '0;
                        default: st_d.bad    = 1'b1;
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign bus_ready = !st_q.pend;
    assign chr_valid = st_q.pend;
    assign chr_data  = st_q.outbox[7:0];
    assign halt      = st_q.halt;
    assign bad_cmd   = st_q.bad;
endmodule

// File: rtl/hostmbx_chk.sv
module hostmbx_chk #(
    parameter int BUS_W  = 32,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic              bus_ready,
    input logic              chr_valid,
    input logic              chr_ready,
    input logic [7:0]        chr_data,
    input logic              halt,
    input logic              bad_cmd
);
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_addr inside {ADDR_W'(0), ADDR_W'(4), ADDR_W'(8), ADDR_W'(12)}) |-> bus_rdata == '0); // R2
    AST_PUT_RAISES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_write && bus_ready && bus_addr == ADDR_W'(4)
        && bus_wdata == BUS_W'(32'h0101_0000) |=> chr_valid); // R6
    AST_CHAR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        chr_valid && !chr_ready |=> chr_valid && $stable(chr_data)); // R6
    AST_ACCEPT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        chr_valid && chr_ready |=> !chr_valid); // R7
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> halt); // R5
    AST_BAD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        bad_cmd |=> bad_cmd); // R10
endmodule

bind hostmbx_top hostmbx_chk #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_hostmbx_top.sv
module test_hostmbx_top;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [BUS_W-1:0]  bus_wdata = '0;
    logic [BUS_W-1:0]  bus_rdata;
    logic              bus_ready;
    logic              chr_valid;
    logic              chr_ready = 1'b1;
    logic [7:0]        chr_data;
    logic              halt;
    logic              bad_cmd;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 0;

    // behavioural reference state
    logic [63:0] m_out, m_in;
    bit          m_pend, m_halt, m_bad;

    always #2 clk = ~clk;

    hostmbx_top #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) i_hostmbx_top (.*);

    function automatic logic [31:0] m_read(input logic [ADDR_W-1:0] a);
        if (a == 0) return m_out[31:0];
        if (a == 4) return m_out[63:32];
        if (a == 8) return m_in[31:0];
        if (a == 12) return m_in[63:32];
        return 32'h0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_out = 0; m_in = 0; m_pend = 0; m_halt = 0; m_bad = 0;
        end else if (m_pend) begin
            if (chr_ready) begin
                m_out = 0; m_in = 64'h0101_0000_0000_0000; m_pend = 0;
            end
        end else if (bus_valid && bus_write) begin
            if (bus_addr == 0) m_out[31:0] = bus_wdata;
            else if (bus_addr == 8) m_in[31:0] = bus_wdata;
            else if (bus_addr == 12) m_in[63:32] = bus_wdata;
            else if (bus_addr == 4) begin
                m_out[63:32] = bus_wdata;
                if (m_out == 64'd1) m_halt = 1;
                else if (m_out[63:56] == 8'd1 && m_out[55:48] == 8'd1) m_pend = 1;
                else if (m_out[63:56] == 8'd1 && m_out[55:48] == 8'd0) m_out = 0;
                else m_bad = 1;
            end
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R1 rdata", 64'(bus_rdata), 64'(m_read(bus_addr)));
            check("R8 bus_ready", 64'(bus_ready), 64'(!m_pend));
            check("R6 chr_valid", 64'(chr_valid), 64'(m_pend));
            if (m_pend) check("R6 chr_data", 64'(chr_data), 64'(m_out[7:0]));
            check("R5 halt", 64'(halt), 64'(m_halt));
            check("R10 bad_cmd", 64'(bad_cmd), 64'(m_bad));
        end
    end

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); #1;
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic rd(input string tag, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
        @(negedge clk); #1;
        bus_addr = a; #1;
        check(tag, 64'(bus_rdata), 64'(exp));
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected below 20000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        // R11 reset state
        rd("R11 out lo", 0, 0); rd("R11 out hi", 4, 0);
        rd("R11 in lo", 8, 0);  rd("R11 in hi", 12, 0);
        check("R11 flags", 64'({halt, bad_cmd, chr_valid}), 64'(0));
        // R1 / R3 word access
        wr(8, 32'hA5A5_5A5A); wr(12, 32'h1234_5678); wr(0, 32'hDEAD_BEEF);
        rd("R1 in lo", 8, 32'hA5A5_5A5A); rd("R3 in hi", 12, 32'h1234_5678);
        rd("R3 out lo", 0, 32'hDEAD_BEEF); rd("R3 out hi untouched", 4, 0);
        // R2 unmapped offsets
        wr(16, 32'hFFFF_FFFF); wr(1, 32'h0BAD_0BAD); wr(31, 32'h1111_1111);
        rd("R2 read 16", 16, 0); rd("R2 read 1", 1, 0); rd("R2 read 13", 13, 0);
        rd("R2 out lo kept", 0, 32'hDEAD_BEEF); rd("R2 in hi kept", 12, 32'h1234_5678);
        // R4 / R6 / R7 character with ready sink
        wr(0, 32'h0000_0041); wr(4, 32'h0101_0000);
        repeat (2) @(negedge clk);
        rd("R7 out lo cleared", 0, 0); rd("R7 out hi cleared", 4, 0);
        rd("R7 ack lo", 8, 0); rd("R7 ack hi", 12, 32'h0101_0000);
        // R8 stalled sink
        wr(8, 32'h0000_0077);
        chr_ready = 0;
        wr(0, 32'h0000_005A); wr(4, 32'h0101_ABCD);
        check("R6 valid while stalled", 64'(chr_valid), 64'(1));
        check("R6 data while stalled", 64'(chr_data), 64'h5A);
        wr(8, 32'hCAFE_F00D); wr(12, 32'hCAFE_F00D);
        repeat (3) @(negedge clk);
        rd("R8 in lo kept", 8, 32'h0000_0077); rd("R8 out hi held", 4, 32'h0101_ABCD);
        #1 chr_ready = 1;
        repeat (2) @(negedge clk);
        rd("R7 ack after stall", 12, 32'h0101_0000); rd("R7 ack lo zero", 8, 0);
        // R9 discard
        wr(8, 32'h0000_0055); wr(0, 32'h0000_0099); wr(4, 32'h0100_0000);
        rd("R9 out lo cleared", 0, 0); rd("R9 out hi cleared", 4, 0);
        rd("R9 inbox kept", 8, 32'h0000_0055);
        check("R9 no char", 64'(chr_valid), 64'(0));
        // R10 unsupported
        wr(0, 32'h0000_0007); wr(4, 32'h0200_0001);
        check("R10 flag", 64'(bad_cmd), 64'(1));
        rd("R10 out lo kept", 0, 32'h0000_0007); rd("R10 out hi kept", 4, 32'h0200_0001);
        // R5 shutdown
        wr(0, 32'h0000_0001); wr(4, 32'h0000_0000);
        check("R5 halt set", 64'(halt), 64'(1));
        rd("R5 out lo kept", 0, 32'h0000_0001);
        wr(0, 32'h0000_0000); wr(4, 32'h0100_0000);
        check("R5 halt sticky", 64'(halt), 64'(1));
        // R11 reset again
        @(negedge clk); #1 rst_n = 0;
        @(negedge clk); #1 rst_n = 1;
        check("R11 flags after reset", 64'({halt, bad_cmd, chr_valid}), 64'(0));
        rd("R11 out lo", 0, 0); rd("R11 in hi", 12, 0);
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule